// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is the bus interface of a small 8-bit processor. A 16-bit address is split across two groups of pins. The high byte has its own lines. The low byte shares its lines with data. The internal core hands the block one read or write request at a time, aimed at either memory or I/O space. The block turns each request into a framed machine cycle. The cycle has four kinds of state:

- an address state, in which a latch-enable strobe marks the shared lines as carrying the low address;
- a strobe state;
- any number of wait states, inserted while the addressed device holds READY low;
- a closing state.

A read returns its data to the core together with a one-cycle completion pulse.

Between machine cycles, an external master may request the bus on HOLD. The block lets the cycle in progress finish, then acknowledges on HLDA and drops the output enables of every address, data and control pin. While reset is active, those same enables are off.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: In the cycle after a request is acknowledged, the block is in the address state. In that state `ale_o`=1, `ad_oe_o`=1, `ad_o` carries address bits [7:0], and both strobes are high. ALE lasts exactly one clock, and the low address is still driven on the clock in which ALE falls.
- R2: For a write (`req_write_i`=1), `wr_n_o`=0 and `rd_n_o`=1 from the state after the address state through the closing state. During that time `ad_o` carries the write data with `ad_oe_o`=1.
- R3: For a read, `rd_n_o`=0 and `wr_n_o`=1 from the state after the address state through the closing state, with `ad_oe_o`=0. The value on `ad_i` during the closing state appears on `rdata_o` alongside the completion pulse.
- R4: From the address state through the closing state, `iom_o` equals the request's I/O flag (1 = I/O, 0 = memory) and `addr_hi_o` equals address bits [15:8].
- R5: READY is sampled on the first strobe state and on every wait state. Each low sample adds one wait state. The closing state follows the first high sample. READY has no effect in the address state.
- R6: `done_o` is high for exactly one clock, in the cycle after the closing state. Both strobes are high in that cycle.
- R7: `req_ack_o` is high only when the block is idle, `req_valid_i`=1 and `hold_i`=0. The acknowledged address, direction, space and data are used for the whole machine cycle.
- R8: A HOLD that arrives during a machine cycle does not cut it short. From the idle state, `hold_i`=1 has priority over a pending request. The block then sets `hlda_o`=1 and clears `addr_oe_o`, `ad_oe_o` and `ctrl_oe_o`.
- R9: `hlda_o` falls one clock after `hold_i` is seen low. A pending request is acknowledged in that cycle, and its address state follows.
- R10: While `rst_i`=1, all output enables, `hlda_o` and `req_ack_o` are 0. After release the block is idle with address and control pins driven, both strobes high, ALE low, and the shared lines undriven.
- R11: `rd_n_o` and `wr_n_o` are never low together, and neither is low while `ale_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Core has a request pending |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| req_ack_o | output | 1 | Request accepted this clock |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Data returned by the last read |
| addr_hi_o | output | ADDR_W-DATA_W | High address byte |
| addr_oe_o | output | 1 | Output enable for `addr_hi_o` |
| ad_o | output | DATA_W | Shared low address / data, driven value |
| ad_i | input | DATA_W | Shared low address / data, sensed value |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| ale_o | output | 1 | Address latch enable strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| iom_o | output | 1 | Space select, 1 = I/O |
| ctrl_oe_o | output | 1 | Output enable for ALE, strobes and space select |
| ready_i | input | 1 | Device ready; low adds wait states |
| hold_i | input | 1 | External bus request |
| hlda_o | output | 1 | Bus surrendered |

## Verification
The bench builds the block with its default widths: ADDR_W=16 and DATA_W=8. This makes the high and low address halves distinct 8-bit fields. The bench addresses use different values in the two halves, so a swap of the halves, or a wrong byte on the shared lines during the address state, shows up directly. It also makes the 8-bit read path from the shared lines to `rdata_o` observable with a fresh sensed value every clock, so a capture on the wrong clock gives a wrong value.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int MB_ADDR_W = 16;
    localparam int MB_DATA_W = 8;

    typedef enum logic [2:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_TW   = 3'd3,
        BS_T3   = 3'd4,
        BS_HOLD = 3'd5
    } bus_st_e;

    // Strobe phase: read or write strobe is active.
    function automatic logic in_strobe(bus_st_e s);
        return (s == BS_T2) || (s == BS_TW) || (s == BS_T3);
    endfunction

    // Any state that belongs to a machine cycle.
    function automatic logic in_cycle(bus_st_e s);
        return (s == BS_T1) || in_strobe(s);
    endfunction

    // States in which READY is sampled.
    function automatic logic samples_ready(bus_st_e s);
        return (s == BS_T2) || (s == BS_TW);
    endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    req_valid_i,
    input  logic    ready_i,
    input  logic    hold_i,
    output bus_st_e st_o,
    output logic    accept_o,
    output logic    done_o
);

    bus_st_e st_q;
    bus_st_e st_d;
    logic    done_q;

    assign accept_o = (st_q == BS_IDLE) && req_valid_i && !hold_i && !rst_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_IDLE: begin
                if (hold_i)           st_d = BS_HOLD;
                else if (req_valid_i) st_d = BS_T1;
            end
            BS_T1:   st_d = BS_T2;
            BS_T2,
            BS_TW:   st_d = ready_i ? BS_T3 : BS_TW;
            BS_T3:   st_d = BS_IDLE;
            BS_HOLD: if (!hold_i) st_d = BS_IDLE;
            default: st_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= BS_IDLE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == BS_T3);
        end
    end

    assign st_o   = st_q;
    assign done_o = done_q;

    // R5: a low READY sample keeps the cycle in a wait state
    a_r5_wait_on_not_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        (samples_ready(st_q) && !ready_i) |=> (st_q == BS_TW));

    // R5: READY is ignored in the address state
    a_r5_t1_to_t2: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BS_T1) |=> (st_q == BS_T2));

    // R6: completion is a single-clock pulse that follows the closing state
    a_r6_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |=> !done_q);

    // R7: a machine cycle only starts from idle
    a_r7_t1_from_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BS_T1) |-> ($past(st_q) == BS_IDLE));

    // R8: hold is only granted between machine cycles
    a_r8_hold_between_cycles: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BS_HOLD) |-> ($past(st_q) == BS_IDLE || $past(st_q) == BS_HOLD));

endmodule

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
    import mbus_pkg::*;
#(
    parameter int ADDR_W = MB_ADDR_W,
    parameter int DATA_W = MB_DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              accept_i,
    input  bus_st_e           st_i,
    input  logic              req_write_i,
    input  logic              req_io_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic              cur_write_o,
    output logic              cur_io_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [DATA_W-1:0] cur_wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              write_q;
    logic              io_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            write_q <= 1'b0;
            io_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept_i) begin
            write_q <= req_write_i;
            io_q    <= req_io_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                            rdata_q <= '0;
        else if (st_i == BS_T3 && !write_q)   rdata_q <= ad_i;
    end

    assign cur_write_o = write_q;
    assign cur_io_o    = io_q;
    assign cur_addr_o  = addr_q;
    assign cur_wdata_o = wdata_q;
    assign rdata_o     = rdata_q;

    // R7: the captured request does not move while a cycle is under way
    a_r7_request_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i != BS_IDLE) |=> ($stable(addr_q) && $stable(write_q) &&
                               $stable(io_q) && $stable(wdata_q)));

    // R3: read data only changes as a read cycle closes
    a_r3_rdata_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(rdata_q) |-> ($past(st_i) == BS_T3));

endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = MB_ADDR_W,
    parameter int DATA_W = MB_DATA_W
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  bus_st_e                  st_i,
    input  logic                     cur_write_i,
    input  logic                     cur_io_i,
    input  logic [ADDR_W-1:0]        cur_addr_i,
    input  logic [DATA_W-1:0]        cur_wdata_i,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                     addr_oe_o,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic                     iom_o,
    output logic                     ctrl_oe_o,
    output logic                     hlda_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic strobe_ph;
    logic surrendered;

    always_comb begin
        strobe_ph   = in_strobe(st_i);
        surrendered = (st_i == BS_HOLD);

        addr_hi_o = cur_addr_i[ADDR_W-1 -: HI_W];
        iom_o     = cur_io_i;
        ale_o     = (st_i == BS_T1);
        ad_o      = (st_i == BS_T1) ? cur_addr_i[DATA_W-1:0] : cur_wdata_i;
        rd_n_o    = !(strobe_ph && !cur_write_i);
        wr_n_o    = !(strobe_ph && cur_write_i);

        ad_oe_o   = !rst_i && ((st_i == BS_T1) || (strobe_ph && cur_write_i));
        addr_oe_o = !rst_i && !surrendered;
        ctrl_oe_o = !rst_i && !surrendered;
        hlda_o    = !rst_i && surrendered;
    end

    // R11: strobes are exclusive and never overlap the address strobe
    a_r11_strobe_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(!rd_n_o && !wr_n_o) && !(ale_o && (!rd_n_o || !wr_n_o)));

    // R1: the low address is still driven on the clock ALE falls
    a_r1_addr_at_ale_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |=> ($past(ad_oe_o) && !ale_o));

    // R4: space select does not change inside a machine cycle
    a_r4_space_steady: assert property (@(posedge clk_i) disable iff (rst_i)
        in_strobe(st_i) |-> ($stable(iom_o) && $stable(addr_hi_o)));

    // R8: all pins are released while the bus is surrendered
    a_r8_float_in_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        hlda_o |-> (!addr_oe_o && !ad_oe_o && !ctrl_oe_o));

    // R10: reset floats every pin
    a_r10_float_in_reset: assert property (@(posedge clk_i)
        rst_i |-> (!addr_oe_o && !ad_oe_o && !ctrl_oe_o && !hlda_o));

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = MB_ADDR_W,
    parameter int DATA_W = MB_DATA_W
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     req_valid_i,
    input  logic                     req_write_i,
    input  logic                     req_io_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    output logic                     req_ack_o,
    output logic                     done_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                     addr_oe_o,
    output logic [DATA_W-1:0]        ad_o,
    input  logic [DATA_W-1:0]        ad_i,
    output logic                     ad_oe_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic                     iom_o,
    output logic                     ctrl_oe_o,
    input  logic                     ready_i,
    input  logic                     hold_i,
    output logic                     hlda_o
);

    bus_st_e           st;
    logic              accept;
    logic              cur_write;
    logic              cur_io;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mbus_seq u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_valid_i (req_valid_i),
        .ready_i     (ready_i),
        .hold_i      (hold_i),
        .st_o        (st),
        .accept_o    (accept),
        .done_o      (done_o)
    );

    mbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .accept_i    (accept),
        .st_i        (st),
        .req_write_i (req_write_i),
        .req_io_i    (req_io_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .ad_i        (ad_i),
        .cur_write_o (cur_write),
        .cur_io_o    (cur_io),
        .cur_addr_o  (cur_addr),
        .cur_wdata_o (cur_wdata),
        .rdata_o     (rdata_o)
    );

    mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .st_i        (st),
        .cur_write_i (cur_write),
        .cur_io_i    (cur_io),
        .cur_addr_i  (cur_addr),
        .cur_wdata_i (cur_wdata),
        .addr_hi_o   (addr_hi_o),
        .addr_oe_o   (addr_oe_o),
        .ad_o        (ad_o),
        .ad_oe_o     (ad_oe_o),
        .ale_o       (ale_o),
        .rd_n_o      (rd_n_o),
        .wr_n_o      (wr_n_o),
        .iom_o       (iom_o),
        .ctrl_oe_o   (ctrl_oe_o),
        .hlda_o      (hlda_o)
    );

    assign req_ack_o = accept;

    // R9: after the bus comes back, ack is possible only with HOLD low
    a_r9_no_ack_in_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        req_ack_o |-> (!hold_i && !hlda_o));

endmodule

// File: tb/mbus_cycle_ctrl_tb.sv
`timescale 1ns/100ps
module mbus_cycle_ctrl_tb;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef struct {
        bit          w;
        bit          io;
        bit [AW-1:0] a;
        bit [DW-1:0] d;
    } rq_t;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1;
    logic          req_valid_i = 1'b0;
    logic          req_write_i = 1'b0;
    logic          req_io_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0;
    logic          req_ack_o, done_o;
    logic [DW-1:0] rdata_o;
    logic [AW-DW-1:0] addr_hi_o;
    logic          addr_oe_o;
    logic [DW-1:0] ad_o;
    logic [DW-1:0] ad_i = '0;
    logic          ad_oe_o, ale_o, rd_n_o, wr_n_o, iom_o, ctrl_oe_o;
    logic          ready_i = 1'b1;
    logic          hold_i = 1'b0;
    logic          hlda_o;

    always #2 clk = ~clk;

    mbus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk_i(clk), .rst_i(rst_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_io_i(req_io_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_ack_o(req_ack_o), .done_o(done_o), .rdata_o(rdata_o),
        .addr_hi_o(addr_hi_o), .addr_oe_o(addr_oe_o),
        .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe_o),
        .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .iom_o(iom_o),
        .ctrl_oe_o(ctrl_oe_o), .ready_i(ready_i), .hold_i(hold_i), .hlda_o(hlda_o)
    );

    // Reference model: phase 0 idle, 1 address, 2 strobe/wait, 3 closing, 4 surrendered
    rq_t     q[$];
    rq_t     cur;
    int      mph = 0;
    bit      mdone = 0;
    bit [DW-1:0] mrdata = '0;
    bit [DW-1:0] noise = 8'h5A;

    int vectors = 0;
    int errs = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit strobe;
        strobe = (mph == 2) || (mph == 3);
        vectors++;
        if (rst_i) begin
            chk("R10", "addr_oe", addr_oe_o, 0);
            chk("R10", "ad_oe", ad_oe_o, 0);
            chk("R10", "ctrl_oe", ctrl_oe_o, 0);
            chk("R10", "hlda", hlda_o, 0);
            chk("R10", "ack", req_ack_o, 0);
            return;
        end
        chk("R7", "ack", req_ack_o, (mph == 0 && q.size() > 0 && !hold_i) ? 1 : 0);
        chk("R8", "hlda", hlda_o, (mph == 4) ? 1 : 0);
        chk("R8", "addr_oe", addr_oe_o, (mph != 4) ? 1 : 0);
        chk("R8", "ctrl_oe", ctrl_oe_o, (mph != 4) ? 1 : 0);
        chk("R1", "ale", ale_o, (mph == 1) ? 1 : 0);
        chk("R3", "rd_n", rd_n_o, (strobe && !cur.w) ? 0 : 1);
        chk("R2", "wr_n", wr_n_o, (strobe && cur.w) ? 0 : 1);
        chk("R11", "strobe overlap", int'(!rd_n_o && !wr_n_o), 0);
        chk("R2", "ad_oe", ad_oe_o, (mph == 1 || (strobe && cur.w)) ? 1 : 0);
        if (mph == 1) chk("R1", "ad low address", ad_o, cur.a[DW-1:0]);
        if (strobe && cur.w) chk("R2", "ad write data", ad_o, cur.d);
        if (mph >= 1 && mph <= 3) begin
            chk("R4", "addr_hi", addr_hi_o, cur.a[AW-1:DW]);
            chk("R4", "iom", iom_o, cur.io);
        end
        chk("R6", "done", done_o, mdone);
        if (mdone && !cur.w) chk("R3", "rdata", rdata_o, mrdata);
    endtask

    task automatic model_step();
        if (rst_i) begin
            mph = 0;
            mdone = 0;
            return;
        end
        mdone = 0;
        case (mph)
            0: if (hold_i) mph = 4;
               else if (q.size() > 0) begin cur = q.pop_front(); mph = 1; end
            1: mph = 2;
            2: if (ready_i) mph = 3;
            3: begin mph = 0; mdone = 1; if (!cur.w) mrdata = ad_i; end
            4: if (!hold_i) mph = 0;
            default: mph = 0;
        endcase
    endtask

    task automatic tick();
        @(negedge clk);
        noise = {noise[6:0], noise[7] ^ noise[5] ^ noise[4] ^ noise[3]};
        ad_i = noise;
        req_valid_i = (q.size() > 0);
        if (q.size() > 0) begin
            req_write_i = q[0].w;
            req_io_i    = q[0].io;
            req_addr_i  = q[0].a;
            req_wdata_i = q[0].d;
        end
        #1;
        compare();
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push(input bit w, input bit io, input bit [AW-1:0] a, input bit [DW-1:0] d);
        rq_t r;
        r.w = w; r.io = io; r.a = a; r.d = d;
        q.push_back(r);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        // R10: reset with a request already pending, then release
        push(0, 0, 16'h1234, 8'h00);
        ticks(3);
        rst_i = 1'b0;
        // R1, R3, R4, R6: memory read, no waits
        ticks(6);
        // R2, R4: I/O write, no waits
        push(1, 1, 16'h00AB, 8'h3C);
        ticks(6);
        // R5: READY low before and through the access, three wait states
        ready_i = 1'b0;
        push(0, 1, 16'hC3E7, 8'h00);
        ticks(5);
        ready_i = 1'b1;
        ticks(4);
        // R5: write with a single wait state
        push(1, 0, 16'h5AA5, 8'h81);
        ticks(2);
        ready_i = 1'b0;
        tick();
        ready_i = 1'b1;
        ticks(5);
        // R7: back-to-back requests
        push(0, 0, 16'h0102, 8'h00);
        push(1, 1, 16'hFE01, 8'hEE);
        push(0, 1, 16'h7F80, 8'h00);
        ticks(16);
        // R8: HOLD arrives mid-cycle, cycle completes first
        push(1, 0, 16'h2468, 8'h99);
        ticks(2);
        hold_i = 1'b1;
        ticks(3);
        push(0, 0, 16'h1357, 8'h00);
        ticks(4);
        // R9: release, pending request is accepted after HLDA drops
        hold_i = 1'b0;
        ticks(7);
        // R8: HOLD and request together in idle, HOLD wins
        hold_i = 1'b1;
        push(1, 1, 16'h9ABC, 8'h42);
        ticks(3);
        hold_i = 1'b0;
        ticks(7);
        // R10: reset in the middle of a write cycle
        push(1, 0, 16'hBEEF, 8'h77);
        ticks(3);
        rst_i = 1'b1;
        ticks(2);
        rst_i = 1'b0;
        // R11: one more read after recovery
        push(0, 0, 16'h4321, 8'h00);
        ticks(8);
        summary();
    end

endmodule